// File: doc/BRIEF.md
# Binary Field Repeated Quadrupling Unit

This unit raises an element of the binary extension field GF(2^233) to the power 4^n in one clock cycle. A chain of identical quadrupling stages, each made of two squarings with reduction modulo the trinomial x^233 + x^74 + 1, sits between the operand input and a selection multiplexer. A 4-bit select input picks the point in the chain whose value becomes the result, so one pass applies between zero and fourteen consecutive x^4 operations.

The block is the repeated-power step of an addition-chain field inversion, used when projective coordinates are converted back to affine form. The inversion sequencer drives the operand from the register file. It sets the select to the number of quadruplings that the chain step needs, and raises the enable bit of its control word in the cycle whose result must be captured. The result sits in an output register that loads only while enable is high. A parameter can remove that register, which makes the unit purely combinational.

Top module: `quad_power_unit`

## Requirements
- R1: While the synchronous active-low reset `rst_n` is low at a rising clock edge, `result` is cleared to all zeros after that edge.
- R2: Select value 0 loads the operand into `result` unchanged.
- R3: Select value s, for s from 1 to 14, loads a^(4^s) into `result`. Here a is the operand, and field elements are polynomials in x with bit i holding the coefficient of x^i, reduced modulo x^233 + x^74 + 1.
- R4: Select value 15 loads the same value as select 14, a^(4^14).
- R5: While `en` is low at a rising edge, `result` keeps its previous value, whatever the operand and select are doing.
- R6: `result` changes only at a rising clock edge. A change of operand or select between edges leaves it untouched until the next edge.
- R7: For every select value, an operand of 0 gives 0 and an operand of 1 (only bit 0 set) gives 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Load enable for the result register |
| operand | input | 233 | Field element to be raised |
| sel | input | 4 | Number of quadruplings (15 saturates to 14) |
| result | output | 233 | Registered power of the operand |

## Verification
On every cycle the assertions check the reset clear, the hold while enable is low, the pass-through at select 0, and the fixed points 0 and 1. They use only port values across one edge. Whether the chain reduces correctly for select 1 to 15 can be shown only by the bench. Its scenarios cover every select value with random operands and the all-ones element. They compare each one against an independent multiply-and-reduce model, and they also probe the output between edges.

// File: rtl/quad_pkg.sv
package quad_pkg;
    localparam int FIELD_M   = 233;
    localparam int TRI_K     = 74;
    localparam int STAGES    = 14;
    localparam int SEL_W     = 4;

    typedef logic [FIELD_M-1:0] elem_t;
endpackage

// File: rtl/gf_squarer.sv
// Squaring in GF(2^M) modulo x^M + x^K + 1: spread to even bits, fold the top down.
module gf_squarer #(
    parameter int M = quad_pkg::FIELD_M,
    parameter int K = quad_pkg::TRI_K
) (
    input  logic [M-1:0] din,
    output logic [M-1:0] dout
);
    localparam int WIDE = 2*M - 1;

    logic [WIDE-1:0] wide;

    always_comb begin
        wide = '0;
        for (int i = 0; i < M; i++) begin
            wide[2*i] = din[i];
        end
        // Descending order: every fold target lies below the bit being folded.
        for (int j = WIDE - 1; j >= M; j--) begin
            if (wide[j]) begin
                wide[j - M + K] = ~wide[j - M + K];
                wide[j - M]     = ~wide[j - M];
                wide[j]         = 1'b0;
            end
        end
        dout = wide[M-1:0];
    end
endmodule

// File: rtl/quad_stage.sv
// One x^4 step: two cascaded squarings.
module quad_stage #(
    parameter int M = quad_pkg::FIELD_M,
    parameter int K = quad_pkg::TRI_K
) (
    input  logic [M-1:0] din,
    output logic [M-1:0] dout
);
    logic [M-1:0] half;

    gf_squarer #(.M(M), .K(K)) i_sq_first  (.din(din),  .dout(half));
    gf_squarer #(.M(M), .K(K)) i_sq_second (.din(half), .dout(dout));
endmodule

// File: rtl/quad_chain.sv
// Chain of quadrupling stages with a saturating tap selector.
module quad_chain #(
    parameter int M      = quad_pkg::FIELD_M,
    parameter int K      = quad_pkg::TRI_K,
    parameter int STAGES = quad_pkg::STAGES,
    parameter int SEL_W  = quad_pkg::SEL_W
) (
    input  logic [M-1:0]     din,
    input  logic [SEL_W-1:0] sel,
    output logic [M-1:0]     dout
);
    localparam int TAPS = STAGES + 1;

    logic [M-1:0] tap [TAPS];

    assign tap[0] = din;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        quad_stage #(.M(M), .K(K)) i_stage (.din(tap[g]), .dout(tap[g+1]));
    end

    always_comb begin
        dout = tap[STAGES];
        for (int t = 0; t < TAPS; t++) begin
            if (int'(sel) == t) begin
                dout = tap[t];
            end
        end
    end
endmodule

// File: rtl/quad_power_unit.sv
module quad_power_unit #(
    parameter int M       = quad_pkg::FIELD_M,
    parameter int K       = quad_pkg::TRI_K,
    parameter int STAGES  = quad_pkg::STAGES,
    parameter int SEL_W   = quad_pkg::SEL_W,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [M-1:0]     operand,
    input  logic [SEL_W-1:0] sel,
    output logic [M-1:0]     result
);
    logic [M-1:0] chain_out;

    quad_chain #(.M(M), .K(K), .STAGES(STAGES), .SEL_W(SEL_W)) i_chain (
        .din  (operand),
        .sel  (sel),
        .dout (chain_out)
    );

    if (REG_OUT) begin : g_reg
        logic [M-1:0] result_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                result_q <= '0;
            end else if (en) begin
                result_q <= chain_out;
            end
        end
        assign result = result_q;
    end else begin : g_comb
        assign result = chain_out;
    end
endmodule

// File: rtl/quad_power_unit_chk.sv
module quad_power_unit_chk #(
    parameter int M       = quad_pkg::FIELD_M,
    parameter int SEL_W   = quad_pkg::SEL_W,
    parameter bit REG_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [M-1:0]     operand,
    input logic [SEL_W-1:0] sel,
    input logic [M-1:0]     result
);
    localparam logic [M-1:0] ONE = {{(M-1){1'b0}}, 1'b1};

    if (REG_OUT) begin : g_props
        a_r1_reset_clears: assert property (@(posedge clk)
            !rst_n |=> result == '0);

        a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !en |=> $stable(result));

        a_r2_select_zero_passes: assert property (@(posedge clk) disable iff (!rst_n)
            (en && sel == '0) |=> result == $past(operand));

        a_r7_zero_fixed: assert property (@(posedge clk) disable iff (!rst_n)
            (en && operand == '0) |=> result == '0);

        a_r7_one_fixed: assert property (@(posedge clk) disable iff (!rst_n)
            (en && operand == ONE) |=> result == ONE);
    end
endmodule

bind quad_power_unit quad_power_unit_chk #(
    .M(M), .SEL_W(SEL_W), .REG_OUT(REG_OUT)
) i_quad_power_unit_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .operand(operand), .sel(sel), .result(result)
);

// File: tb/test_quad_power_unit.sv
`timescale 1ns/1ps
module test_quad_power_unit;
    localparam int M = 233;
    localparam int K = 74;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic [M-1:0] operand = '0;
    logic [3:0]   sel = '0;
    logic [M-1:0] result;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    logic [M-1:0] expv = '0;

    always #2.5 clk = ~clk;

    quad_power_unit i_quad_power_unit (
        .clk(clk), .rst_n(rst_n), .en(en), .operand(operand), .sel(sel), .result(result)
    );

    // a*a mod (x^M + x^K + 1) by left-to-right shift-and-add multiplication.
    function automatic logic [M-1:0] model_sq(input logic [M-1:0] a);
        logic [M-1:0] r = '0;
        logic carry;
        for (int i = M - 1; i >= 0; i--) begin
            carry = r[M-1];
            r = r << 1;
            if (carry) begin
                r[K] = ~r[K];
                r[0] = ~r[0];
            end
            if (a[i]) r = r ^ a;
        end
        return r;
    endfunction

    function automatic logic [M-1:0] model_pow(input logic [M-1:0] a, input int s);
        logic [M-1:0] r = a;
        int n = (s > 14) ? 14 : s;
        for (int q = 0; q < 2*n; q++) r = model_sq(r);
        return r;
    endfunction

    function automatic logic [M-1:0] rand_elem();
        logic [M-1:0] r = '0;
        for (int w = 0; w < 8; w++) r = (r << 32) | M'($urandom);
        return r;
    endfunction

    task automatic check(input string tag, input logic [M-1:0] want);
        checks++;
        if (result !== want) begin
            errors++;
            $display("FAIL %s: result=%h expected=%h", tag, result, want);
        end
    endtask

    // One cycle: drive at negedge, probe before edge (R6), update model at edge, check after.
    task automatic step(input string tag, input logic r_n, input logic e,
                        input logic [M-1:0] a, input logic [3:0] s);
        logic [M-1:0] nxt;
        rst_n = r_n; en = e; operand = a; sel = s;
        #1;
        check("R6", expv);
        if (!r_n)   nxt = '0;
        else if (e) nxt = model_pow(a, int'(s));
        else        nxt = expv;
        @(posedge clk);
        @(negedge clk);
        expv = nxt;
        check(tag, expv);
    endtask

    function automatic string sel_tag(input int s);
        if (s == 0)  return "R2";
        if (s == 15) return "R4";
        return "R3";
    endfunction

    initial begin
        @(negedge clk);
        step("R1", 1'b0, 1'b0, rand_elem(), 4'd3);
        step("R1", 1'b0, 1'b1, rand_elem(), 4'd7);
        for (int s = 0; s < 16; s++) begin
            for (int k = 0; k < 4; k++) step(sel_tag(s), 1'b1, 1'b1, rand_elem(), 4'(s));
            step(sel_tag(s), 1'b1, 1'b1, '1, 4'(s));
            step("R7", 1'b1, 1'b1, '0, 4'(s));
            step("R7", 1'b1, 1'b1, {{(M-1){1'b0}}, 1'b1}, 4'(s));
            step(sel_tag(s), 1'b1, 1'b1, {1'b1, {(M-1){1'b0}}}, 4'(s));
        end
        step("R3", 1'b1, 1'b1, rand_elem(), 4'd9);
        for (int k = 0; k < 6; k++) step("R5", 1'b1, 1'b0, rand_elem(), 4'(k * 3));
        step("R4", 1'b1, 1'b1, rand_elem(), 4'd15);
        step("R1", 1'b0, 1'b1, rand_elem(), 4'd2);
        step("R5", 1'b1, 1'b0, rand_elem(), 4'd5);
        step("R2", 1'b1, 1'b1, rand_elem(), 4'd0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #500000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: result=%h expected=completion", result);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule